// File: doc/BRIEF.md
# SPI Register-Access Master with Wait-State Polling

This engine runs one register read or write transaction at a time against a SPI target that can hold off the data phase with wait states. The host hands over a request (direction, 16-bit register offset, byte count from 1 to `MAX_BYTES`, and for writes the data). The engine then sends a four-byte command header in SPI mode 0. It inspects bit 0 of the byte that came back during the last header byte. If that bit is 0, the target is not ready, and the engine clocks further filler bytes of zeros until a returned byte has bit 0 set. Only then does it move the data bytes. Chip select stays low for the whole exchange.

Requests arrive on a valid/ready port. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and all of its fields are captured in that cycle. While the engine is busy, `req_ready` stays low and the host must hold its request or withdraw it. The result comes back as a one-cycle `rsp_valid` pulse that carries the read data and two error flags. There is no back-pressure on the result, so the host must accept it when it appears. `req_ready` goes high again on the cycle after the pulse.

Multi-byte register values travel least significant byte first: byte `i` of the data vectors is the `i`-th data byte on the bus. Within each byte, bits are shifted MSB first. The SCLK half period is `HALF_DIV` system clocks.

Top module: `spi_regx_master`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write) and the byte count minus one in bits 6:0.
- R2: Header bytes 1, 2 and 3 are 0xD4, the high byte of the register offset and the low byte of the register offset, in that order.
- R3: A request with a length of 0 or greater than `MAX_BYTES` ends with `rsp_valid` and `rsp_err_len` = 1. Chip select is never asserted for it and no SCLK edge is produced.
- R4: If bit 0 of the byte received during header byte 3 is 0, the engine clocks extra bytes with MOSI all zero. It stops after the first received byte whose bit 0 is 1, and the data phase follows directly after that byte.
- R5: If `RETRIES` consecutive wait bytes all return bit 0 = 0, the engine releases chip select and ends with `rsp_err_timeout` = 1, without sending any data byte. Exactly 4 + `RETRIES` bytes appear on the bus.
- R6: Chip select falls once per accepted valid request and stays low from the first header bit through the last data bit. It rises in the same cycle that `rsp_valid` is pulsed. SCLK is low whenever chip select is high.
- R7: On a read, MOSI is zero during the data phase. The `i`-th received data byte is returned in `rsp_rdata[8*i+7:8*i]`, and both error flags are 0.
- R8: On a write, `req_wdata[8*i+7:8*i]` is sent as the `i`-th data byte, MSB first.
- R9: With MISO held high by a pull-up and no target present, a read sees no wait state and returns 0xFF for every requested byte, with no error.
- R10: `req_ready` is high only when the engine is idle and not pulsing `rsp_valid`. It is low from the cycle after acceptance until the cycle after `rsp_valid`, and `rsp_valid` lasts exactly one cycle.
- R11: After reset, chip select is high, SCLK and MOSI are low, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, so the request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register offset |
| req_len | input | LEN_W (7) | Byte count, valid range 1..MAX_BYTES |
| req_wdata | input | 8*MAX_BYTES (512) | Write data, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*MAX_BYTES (512) | Read data, byte i at bits 8i+7:8i |
| rsp_err_len | output | 1 | Length rejected; valid with rsp_valid |
| rsp_err_timeout | output | 1 | Wait-state retry limit reached; valid with rsp_valid |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Master-out data |
| spi_miso | input | 1 | Master-in data, sampled on SCLK rising edges |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume the target changes MISO only after SCLK rising edges, so it is stable at the engine's sampling point. They also assume the host never relies on acceptance while `req_ready` is low. The bench's target model updates MISO on SCLK rising edges and on chip-select falling edges. The host tasks drive requests on falling system-clock edges and release `req_valid` one cycle after acceptance. The target's wait-state count is set per transaction: zero, below `RETRIES`, exactly `RETRIES`, and above it. This reaches both the ready path and the timeout path.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DATA = 2'd3
  } regx_state_e;

  localparam logic [7:0] HDR_FIXED_BYTE = 8'hD4;
  localparam int         HDR_BYTES      = 4;
endpackage

// File: rtl/spi_regx_byte_shifter.sv
module spi_regx_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        sclk <= 1'b0;
        if (start) begin
          active <= 1'b1;
          tx_sh  <= tx_byte;
          mosi   <= tx_byte[7];
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == CNT_W'(HALF_DIV - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
            mosi      <= 1'b0;
          end else begin
            bitn  <= bitn + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
            mosi  <= tx_sh[6];
          end
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_regx_ctrl.sv
module spi_regx_ctrl
  import spi_regx_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int RETRIES   = 4,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [15:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  output logic                   rsp_valid,
  output logic [8*MAX_BYTES-1:0] rsp_rdata,
  output logic                   rsp_err_len,
  output logic                   rsp_err_timeout,
  output logic                   cs_n,
  output logic                   kick,
  output logic [7:0]             tx_byte,
  input  logic                   byte_done,
  input  logic [7:0]             rx_byte
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int RTY_W = (RETRIES > 1) ? $clog2(RETRIES) : 1;

  regx_state_e            st;
  logic [IDX_W-1:0]       idx;
  logic [RTY_W-1:0]       rty;
  logic [LEN_W-1:0]       len_m1;
  logic                   wr_q;
  logic [15:0]            addr_q;
  logic [8*MAX_BYTES-1:0] wbuf;
  logic                   len_bad;
  logic                   last_data;

  assign req_ready = (st == ST_IDLE) && !rsp_valid;
  assign len_bad   = (req_len == '0) || (req_len > LEN_W'(MAX_BYTES));
  assign last_data = (idx == IDX_W'(len_m1));

  always_comb begin
    tx_byte = 8'h00;
    unique case (st)
      ST_HDR: begin
        unique case (idx[1:0])
          2'd0:    tx_byte = {~wr_q, 7'(len_m1)};
          2'd1:    tx_byte = HDR_FIXED_BYTE;
          2'd2:    tx_byte = addr_q[15:8];
          default: tx_byte = addr_q[7:0];
        endcase
      end
      ST_DATA: tx_byte = wr_q ? wbuf[{idx, 3'b000} +: 8] : 8'h00;
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      idx             <= '0;
      rty             <= '0;
      len_m1          <= '0;
      wr_q            <= 1'b0;
      addr_q          <= '0;
      wbuf            <= '0;
      rsp_valid       <= 1'b0;
      rsp_rdata       <= '0;
      rsp_err_len     <= 1'b0;
      rsp_err_timeout <= 1'b0;
      cs_n            <= 1'b1;
      kick            <= 1'b0;
    end else begin
      kick      <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            rsp_err_timeout <= 1'b0;
            if (len_bad) begin
              rsp_err_len <= 1'b1;
              rsp_valid   <= 1'b1;
            end else begin
              rsp_err_len <= 1'b0;
              wr_q        <= req_write;
              addr_q      <= req_addr;
              len_m1      <= req_len - LEN_W'(1);
              wbuf        <= req_wdata;
              idx         <= '0;
              cs_n        <= 1'b0;
              kick        <= 1'b1;
              st          <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (byte_done) begin
            kick <= 1'b1;
            if (idx[1:0] == 2'(HDR_BYTES - 1)) begin
              idx <= '0;
              rty <= '0;
              st  <= rx_byte[0] ? ST_DATA : ST_WAIT;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_WAIT: begin
          if (byte_done) begin
            if (rx_byte[0]) begin
              st   <= ST_DATA;
              kick <= 1'b1;
            end else if (rty == RTY_W'(RETRIES - 1)) begin
              cs_n            <= 1'b1;
              rsp_err_timeout <= 1'b1;
              rsp_valid       <= 1'b1;
              st              <= ST_IDLE;
            end else begin
              rty  <= rty + RTY_W'(1);
              kick <= 1'b1;
            end
          end
        end
        default: begin
          if (byte_done) begin
            if (!wr_q) rsp_rdata[{idx, 3'b000} +: 8] <= rx_byte;
            if (last_data) begin
              cs_n      <= 1'b1;
              rsp_valid <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              idx  <= idx + IDX_W'(1);
              kick <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_regx_master.sv
module spi_regx_master #(
  parameter int MAX_BYTES = 64,
  parameter int RETRIES   = 4,
  parameter int HALF_DIV  = 2,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [15:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  output logic                   rsp_valid,
  output logic [8*MAX_BYTES-1:0] rsp_rdata,
  output logic                   rsp_err_len,
  output logic                   rsp_err_timeout,
  output logic                   spi_sclk,
  output logic                   spi_mosi,
  input  logic                   spi_miso,
  output logic                   spi_cs_n
);
  logic       kick;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       byte_done;

  spi_regx_ctrl #(
    .MAX_BYTES(MAX_BYTES),
    .RETRIES  (RETRIES),
    .LEN_W    (LEN_W)
  ) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_len        (req_len),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .rsp_err_len    (rsp_err_len),
    .rsp_err_timeout(rsp_err_timeout),
    .cs_n           (spi_cs_n),
    .kick           (kick),
    .tx_byte        (tx_byte),
    .byte_done      (byte_done),
    .rx_byte        (rx_byte)
  );

  spi_regx_byte_shifter #(
    .HALF_DIV(HALF_DIV)
  ) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (kick),
    .tx_byte  (tx_byte),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .miso     (spi_miso)
  );
endmodule

// File: rtl/spi_regx_checker.sv
module spi_regx_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err_len,
  input logic rsp_err_timeout,
  input logic spi_sclk,
  input logic spi_cs_n
);
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r6_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> rsp_valid);

  a_r10_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_len_error_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err_len) |-> (spi_cs_n && !rsp_err_timeout));

  a_r5_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err_timeout) |-> spi_cs_n);
endmodule

bind spi_regx_master spi_regx_checker i_chk (.*);

// File: tb/test_spi_regx_master.sv
module test_spi_regx_master;
  localparam int MAXB  = 64;
  localparam int RETR  = 4;
  localparam int LW    = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [15:0]     req_addr = '0;
  logic [LW-1:0]   req_len = '0;
  logic [8*MAXB-1:0] req_wdata = '0;
  logic            rsp_valid;
  logic [8*MAXB-1:0] rsp_rdata;
  logic            rsp_err_len;
  logic            rsp_err_timeout;
  logic            spi_sclk;
  logic            spi_mosi;
  logic            spi_miso;
  logic            spi_cs_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_regx_master i_spi_regx_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err_len(rsp_err_len), .rsp_err_timeout(rsp_err_timeout),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // ---------------- target model ----------------
  int          waits = 0;
  bit          no_target = 1'b0;
  logic [15:0] cur_addr = '0;
  int          bcnt = 0;
  int          bitc = 0;
  int          cs_falls = 0;
  int          sclk_rises = 0;
  logic [7:0]  sh = '0;
  logic [7:0]  mosi_log [0:127];
  logic [7:0]  cur_resp;

  function automatic logic [7:0] pat(logic [15:0] a, int i);
    return a[7:0] ^ 8'(i * 29) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] resp_byte(int n, int w, logic [15:0] a);
    if (n < 3) return 8'hFE;
    if (n <= 3 + w) return (n == 3 + w) ? 8'h01 : 8'h00;
    return pat(a, n - 4 - w);
  endfunction

  assign cur_resp = resp_byte(bcnt, waits, cur_addr);
  assign spi_miso = (no_target || spi_cs_n) ? 1'b1 : cur_resp[3'(7 - bitc)];

  always @(negedge spi_cs_n) begin
    bcnt = 0;
    bitc = 0;
    cs_falls++;
  end

  always @(posedge spi_sclk) begin
    sclk_rises++;
    if (!spi_cs_n) begin
      sh = {sh[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
        if (bcnt < 128) mosi_log[bcnt] = sh;
        bcnt++;
        bitc = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(logic [15:0] a, int i);
    return 8'(i * 7 + 1) ^ a[15:8];
  endfunction

  logic       got_err_len, got_err_to;
  logic [8*MAXB-1:0] got_rdata;
  int         rises_seen;

  task automatic do_req(bit wr, logic [15:0] a, int len, int w);
    int t;
    waits      = w;
    cur_addr   = a;
    cs_falls   = 0;
    sclk_rises = 0;
    bcnt       = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_len   = LW'(len);
    for (int i = 0; i < MAXB; i++) req_wdata[8*i +: 8] = wpat(a, i);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 16'hFFFF;
    req_wdata = '1;
    chk(!req_ready, "R10 ready low after accept", req_ready, 0);
    t = 0;
    while (!rsp_valid && t < 20000) begin
      @(negedge clk);
      t++;
    end
    got_err_len = rsp_err_len;
    got_err_to  = rsp_err_timeout;
    got_rdata   = rsp_rdata;
    rises_seen  = sclk_rises;
    chk(rsp_valid, "R10 response pulse seen", rsp_valid, 1);
    chk(!req_ready, "R10 ready low during pulse", req_ready, 0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 pulse one cycle then ready",
        {rsp_valid, req_ready}, 2'b01);
  endtask

  // vector: {write, addr, len, waits}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 16'h0F00, 7'd4,  4'd0},
    {1'b1, 16'h0018, 7'd4,  4'd2},
    {1'b0, 16'h0024, 7'd1,  4'd1},
    {1'b1, 16'h1234, 7'd64, 4'd0},
    {1'b0, 16'hABCD, 7'd64, 4'd3},
    {1'b0, 16'h0030, 7'd2,  4'd4}
  };

  task automatic check_xfer(bit wr, logic [15:0] a, int len, int w);
    bit ok;
    chk(got_err_len == 0 && got_err_to == 0, "R7 no error flags",
        {got_err_len, got_err_to}, 0);
    chk(cs_falls == 1, "R6 single chip-select assertion", cs_falls, 1);
    chk(bcnt == 4 + w + len, "R4 bytes on bus", bcnt, 4 + w + len);
    chk(mosi_log[0] == {~wr, 7'(len - 1)}, "R1 header byte 0",
        mosi_log[0], {~wr, 7'(len - 1)});
    chk(mosi_log[1] == 8'hD4 && mosi_log[2] == a[15:8] && mosi_log[3] == a[7:0],
        "R2 header bytes 1-3", {mosi_log[1], mosi_log[2], mosi_log[3]},
        {8'hD4, a});
    ok = 1'b1;
    for (int i = 0; i < w; i++) if (mosi_log[4 + i] != 8'h00) ok = 1'b0;
    chk(ok, "R4 wait bytes send zero", ok, 1);
    ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (wr) begin
        if (mosi_log[4 + w + i] != wpat(a, i)) ok = 1'b0;
      end else begin
        if (mosi_log[4 + w + i] != 8'h00) ok = 1'b0;
        if (got_rdata[8*i +: 8] != pat(a, i)) ok = 1'b0;
      end
    end
    if (wr) chk(ok, "R8 write data order", ok, 1);
    else    chk(ok, "R7 read data and zero MOSI", ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && !spi_mosi && !req_ready == 0 && !rsp_valid,
        "R11 reset outputs", {spi_cs_n, spi_sclk, spi_mosi, req_ready, rsp_valid},
        5'b10010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sclk && req_ready && !rsp_valid, "R11 idle after reset",
        {spi_cs_n, spi_sclk, req_ready, rsp_valid}, 4'b1010);

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][27], VEC[v][26:11], int'(VEC[v][10:4]), int'(VEC[v][3:0]));
      check_xfer(VEC[v][27], VEC[v][26:11], int'(VEC[v][10:4]), int'(VEC[v][3:0]));
    end

    // R3: oversize and zero length
    do_req(1'b0, 16'h0040, 65, 0);
    chk(got_err_len && !got_err_to, "R3 length 65 rejected",
        {got_err_len, got_err_to}, 2'b10);
    chk(cs_falls == 0 && rises_seen == 0, "R3 no bus activity for 65",
        cs_falls + rises_seen, 0);
    do_req(1'b1, 16'h0041, 0, 0);
    chk(got_err_len && cs_falls == 0 && rises_seen == 0, "R3 length 0 rejected",
        {got_err_len, 8'(cs_falls), 8'(rises_seen)}, 17'h10000);

    // R5: target never ready within retry limit
    do_req(1'b0, 16'h0050, 4, 9);
    chk(got_err_to && !got_err_len, "R5 timeout flag", {got_err_to, got_err_len}, 2'b10);
    chk(bcnt == 4 + RETR, "R5 no data bytes after timeout", bcnt, 4 + RETR);
    chk(cs_falls == 1 && spi_cs_n, "R5 chip select released", cs_falls, 1);

    // R9: no target, pull-up on MISO
    no_target = 1'b1;
    do_req(1'b0, 16'h0060, 8, 0);
    no_target = 1'b0;
    chk(!got_err_len && !got_err_to && bcnt == 12, "R9 no wait state seen",
        bcnt, 12);
    chk(got_rdata[63:0] == 64'hFFFF_FFFF_FFFF_FFFF, "R9 read returns all ones",
        got_rdata[63:0], 64'hFFFF_FFFF_FFFF_FFFF);

    // R6 / R10 after a timeout the engine still serves a normal request
    do_req(1'b1, 16'h0070, 2, 1);
    check_xfer(1'b1, 16'h0070, 2, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule